// File: doc/BRIEF.md
# PLL Hysteretic Lock Monitor

This block decides whether a phase-locked loop is in lock from per-cycle phase-error measurements. Each phase-detector cycle, an upstream measurement stage presents the magnitude of the phase error, counted in sampling-clock ticks, together with a one-cycle valid strobe. The block raises an active-high lock flag only after a run of consecutive small errors. It lowers the flag only when an error is clearly larger than the tight bound. Because the set and clear bounds differ, the flag does not chatter when the error sits near one limit.

A second part routes one of several internal signals to a single monitor pin under a 3-bit select. The choices are the lock flag, the reference divider output, the feedback divider output, the serial readback line, and a fixed high or low level. The upstream design keeps the select stable. The route is purely combinational.

With the default parameters and a 1 GHz sampling clock, the thresholds are 15 ns to set and 25 ns to clear, and five consecutive cycles are needed to set.

Top module: `pll_lock_monitor`

## Requirements
- R1: After reset, `lock_o` is 0 and the run counter is empty. A fresh lock therefore needs a full run of LOCK_CYCLES small samples.
- R2: While unlocked, LOCK_CYCLES consecutive valid samples with `err_ticks` < SET_TICKS (defaults: 5 samples, 15 ticks) raise `lock_o` on the clock edge that takes the last of those samples. Fewer such samples leave it at 0.
- R3: While unlocked, a valid sample with `err_ticks` >= SET_TICKS empties the run counter. An error of exactly SET_TICKS counts as not small.
- R4: Clock cycles with `err_valid` low change neither `lock_o` nor the run count. A run may span idle gaps.
- R5: While locked, a valid sample with `err_ticks` <= CLR_TICKS (default 25) keeps `lock_o` at 1. This holds for errors between the two thresholds.
- R6: While locked, a valid sample with `err_ticks` > CLR_TICKS clears `lock_o` on the edge that takes it. A later lock again needs a full run of LOCK_CYCLES small samples.
- R7: `mon_o` is 0 for `mon_sel` values 3'b000, 3'b101 and 3'b111, and 1 for 3'b011.
- R8: `mon_o` follows, combinationally, `lock_o` for `mon_sel`=3'b001, `fb_div_pulse` for 3'b010, `ref_div_pulse` for 3'b100, and `ser_out` for 3'b110.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| err_valid | input | 1 | One-cycle strobe marking a new phase-error sample |
| err_ticks | input | ERR_W | Phase-error magnitude in sampling-clock ticks |
| ref_div_pulse | input | 1 | Reference divider output, for monitoring |
| fb_div_pulse | input | 1 | Feedback divider output, for monitoring |
| ser_out | input | 1 | Serial readback line, for monitoring |
| mon_sel | input | 3 | Monitor pin source select |
| lock_o | output | 1 | Active-high digital lock flag |
| mon_o | output | 1 | Monitor pin |

## Verification
Assertions check several behaviours on every cycle. A rising lock flag must follow a valid small-error sample. A locked flag survives any valid sample up to the clear bound and falls after a larger one. An unlocked large sample empties the counter. Idle cycles leave both lock and count untouched, the count stays below the run length, and each monitor select routes its source. Only the bench scenarios can show the sequence effects: the exact sample on which lock appears, a run broken by a boundary error of exactly SET_TICKS, a run that resumes across idle gaps, and the need for a full fresh run after a clear.

// File: rtl/pll_lock_pkg.sv
package pll_lock_pkg;

  typedef enum logic [2:0] {
    MON_LOW  = 3'b000,
    MON_LOCK = 3'b001,
    MON_FB   = 3'b010,
    MON_HIGH = 3'b011,
    MON_REF  = 3'b100,
    MON_SER  = 3'b110
  } mon_src_e;

  // True when a sample is tight enough to extend a lock run.
  function automatic logic err_is_tight(input int unsigned err, input int unsigned set_thr);
    return err < set_thr;
  endfunction

  // True when a sample is loose enough to break an existing lock.
  function automatic logic err_is_loose(input int unsigned err, input int unsigned clr_thr);
    return err > clr_thr;
  endfunction

  // Monitor source choice; unlisted codes give a low level.
  function automatic logic mon_pick(input logic [2:0] sel, input logic lock,
                                    input logic fb, input logic refd, input logic ser);
    logic r;
    case (sel)
      MON_LOCK: r = lock;
      MON_FB:   r = fb;
      MON_HIGH: r = 1'b1;
      MON_REF:  r = refd;
      MON_SER:  r = ser;
      default:  r = 1'b0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/lock_qualifier.sv
module lock_qualifier
  import pll_lock_pkg::*;
#(
  parameter int ERR_W       = 8,
  parameter int SET_TICKS   = 15,
  parameter int CLR_TICKS   = 25,
  parameter int LOCK_CYCLES = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             err_valid,
  input  logic [ERR_W-1:0] err_ticks,
  output logic             lock_o
);

  localparam int CNT_W = $clog2(LOCK_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST_RUN = CNT_W'(LOCK_CYCLES - 1);

  logic             lock_q;
  logic [CNT_W-1:0] cnt_q;

  // Named internal events
  logic tight_err;
  logic loose_err;
  logic run_step;
  logic run_break;
  logic set_evt;
  logic clr_evt;

  assign tight_err = err_is_tight(32'(err_ticks), SET_TICKS);
  assign loose_err = err_is_loose(32'(err_ticks), CLR_TICKS);
  assign run_step  = err_valid && !lock_q && tight_err;
  assign run_break = err_valid && !lock_q && !tight_err;
  assign set_evt   = run_step && (cnt_q == LAST_RUN);
  assign clr_evt   = err_valid && lock_q && loose_err;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lock_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      if (set_evt) begin
        lock_q <= 1'b1;
        cnt_q  <= '0;
      end else if (run_step) begin
        cnt_q  <= cnt_q + 1'b1;
      end else if (run_break) begin
        cnt_q  <= '0;
      end
      if (clr_evt) begin
        lock_q <= 1'b0;
        cnt_q  <= '0;
      end
    end
  end

  assign lock_o = lock_q;

  a_r2_rise_after_tight: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_q) |-> $past(err_valid && tight_err));

  a_r3_break_empties: assert property (@(posedge clk) disable iff (!rst_n)
    (err_valid && !lock_q && !tight_err) |=> (cnt_q == '0));

  a_r4_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !err_valid |=> ($stable(lock_q) && $stable(cnt_q)));

  a_r5_mid_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && err_valid && !loose_err) |=> lock_q);

  a_r6_loose_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && err_valid && loose_err) |=> !lock_q);

  a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CNT_W'(LOCK_CYCLES));

endmodule

// File: rtl/monitor_select.sv
module monitor_select
  import pll_lock_pkg::*;
(
  input  logic [2:0] sel,
  input  logic       lock_i,
  input  logic       fb_i,
  input  logic       ref_i,
  input  logic       ser_i,
  output logic       mon_o
);

  assign mon_o = mon_pick(sel, lock_i, fb_i, ref_i, ser_i);

endmodule

// File: rtl/pll_lock_monitor.sv
module pll_lock_monitor
  import pll_lock_pkg::*;
#(
  parameter int ERR_W       = 8,
  parameter int SET_TICKS   = 15,
  parameter int CLR_TICKS   = 25,
  parameter int LOCK_CYCLES = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             err_valid,
  input  logic [ERR_W-1:0] err_ticks,
  input  logic             ref_div_pulse,
  input  logic             fb_div_pulse,
  input  logic             ser_out,
  input  logic [2:0]       mon_sel,
  output logic             lock_o,
  output logic             mon_o
);

  logic lock_w;

  lock_qualifier #(
    .ERR_W      (ERR_W),
    .SET_TICKS  (SET_TICKS),
    .CLR_TICKS  (CLR_TICKS),
    .LOCK_CYCLES(LOCK_CYCLES)
  ) u_qual (
    .clk      (clk),
    .rst_n    (rst_n),
    .err_valid(err_valid),
    .err_ticks(err_ticks),
    .lock_o   (lock_w)
  );

  monitor_select u_mon (
    .sel   (mon_sel),
    .lock_i(lock_w),
    .fb_i  (fb_div_pulse),
    .ref_i (ref_div_pulse),
    .ser_i (ser_out),
    .mon_o (mon_o)
  );

  assign lock_o = lock_w;

  a_r7_const_low: assert property (@(posedge clk) disable iff (!rst_n)
    (mon_sel == 3'b000 || mon_sel == 3'b101 || mon_sel == 3'b111) |-> !mon_o);

  a_r7_const_high: assert property (@(posedge clk) disable iff (!rst_n)
    (mon_sel == 3'b011) |-> mon_o);

  a_r8_lock_route: assert property (@(posedge clk) disable iff (!rst_n)
    (mon_sel == 3'b001) |-> (mon_o == lock_o));

  a_r8_div_route: assert property (@(posedge clk) disable iff (!rst_n)
    ((mon_sel == 3'b010) |-> (mon_o == fb_div_pulse)) and
    ((mon_sel == 3'b100) |-> (mon_o == ref_div_pulse)) and
    ((mon_sel == 3'b110) |-> (mon_o == ser_out)));

endmodule

// File: tb/tb_pll_lock_monitor.sv
module tb_pll_lock_monitor;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       err_valid = 1'b0;
  logic [7:0] err_ticks = '0;
  logic       ref_div_pulse = 1'b0;
  logic       fb_div_pulse = 1'b0;
  logic       ser_out = 1'b0;
  logic [2:0] mon_sel = 3'b000;
  logic       lock_o;
  logic       mon_o;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  pll_lock_monitor dut (
    .clk(clk), .rst_n(rst_n), .err_valid(err_valid), .err_ticks(err_ticks),
    .ref_div_pulse(ref_div_pulse), .fb_div_pulse(fb_div_pulse), .ser_out(ser_out),
    .mon_sel(mon_sel), .lock_o(lock_o), .mon_o(mon_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // One valid sample; returns at the falling edge after it was taken.
  task automatic send(input int e);
    @(negedge clk);
    err_valid = 1'b1;
    err_ticks = 8'(e);
    @(negedge clk);
    err_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    idle(3);
    check(lock_o == 1'b0, "R1 lock low in reset", lock_o, 0);
    rst_n = 1'b1;
    idle(1);
    check(lock_o == 1'b0, "R1 lock low after reset", lock_o, 0);
  endtask

  task automatic t_first_lock;
    for (int i = 0; i < 4; i++) send(3);
    check(lock_o == 1'b0, "R2 four tight samples do not lock", lock_o, 0);
    send(14);
    check(lock_o == 1'b1, "R2 fifth tight sample locks", lock_o, 1);
  endtask

  task automatic t_hold_mid;
    send(15);
    check(lock_o == 1'b1, "R5 error 15 keeps lock", lock_o, 1);
    send(20);
    check(lock_o == 1'b1, "R5 error 20 keeps lock", lock_o, 1);
    send(25);
    check(lock_o == 1'b1, "R5 error 25 keeps lock", lock_o, 1);
    send(0);
    check(lock_o == 1'b1, "R5 error 0 keeps lock", lock_o, 1);
  endtask

  task automatic t_clear_relock;
    send(26);
    check(lock_o == 1'b0, "R6 error 26 clears lock", lock_o, 0);
    for (int i = 0; i < 4; i++) send(1);
    check(lock_o == 1'b0, "R6 relock needs full run", lock_o, 0);
    send(1);
    check(lock_o == 1'b1, "R6 relock after full run", lock_o, 1);
  endtask

  task automatic t_restart;
    send(200);
    check(lock_o == 1'b0, "R6 large error clears", lock_o, 0);
    for (int i = 0; i < 3; i++) send(2);
    send(15);
    check(lock_o == 1'b0, "R3 error 15 breaks run", lock_o, 0);
    for (int i = 0; i < 4; i++) send(2);
    check(lock_o == 1'b0, "R3 count restarted from zero", lock_o, 0);
    send(2);
    check(lock_o == 1'b1, "R3 lock after full fresh run", lock_o, 1);
  endtask

  task automatic t_gaps;
    send(40);
    send(5);
    send(5);
    idle(10);
    check(lock_o == 1'b0, "R4 idle does not lock", lock_o, 0);
    send(5);
    send(5);
    idle(7);
    check(lock_o == 1'b0, "R4 run resumes after gap", lock_o, 0);
    send(5);
    check(lock_o == 1'b1, "R4 run spans gaps", lock_o, 1);
    err_ticks = 8'd250;
    idle(5);
    check(lock_o == 1'b1, "R4 unstrobed large error ignored", lock_o, 1);
  endtask

  task automatic t_mux;
    bit lk;
    lk = lock_o;
    for (int v = 0; v < 2; v++) begin
      fb_div_pulse  = v[0];
      ref_div_pulse = ~v[0];
      ser_out       = v[0];
      mon_sel = 3'b000; #1 check(mon_o == 1'b0, "R7 sel 000 low", mon_o, 0);
      mon_sel = 3'b101; #1 check(mon_o == 1'b0, "R7 sel 101 low", mon_o, 0);
      mon_sel = 3'b111; #1 check(mon_o == 1'b0, "R7 sel 111 low", mon_o, 0);
      mon_sel = 3'b011; #1 check(mon_o == 1'b1, "R7 sel 011 high", mon_o, 1);
      mon_sel = 3'b010; #1 check(mon_o == v[0], "R8 sel 010 feedback", mon_o, v);
      mon_sel = 3'b100; #1 check(mon_o == ~v[0], "R8 sel 100 reference", mon_o, 1 - v);
      mon_sel = 3'b110; #1 check(mon_o == v[0], "R8 sel 110 serial", mon_o, v);
      mon_sel = 3'b001; #1 check(mon_o == lk, "R8 sel 001 lock", mon_o, lk);
    end
    send(30);
    #1 check(mon_o == 1'b0, "R8 lock route follows clear", mon_o, 0);
    mon_sel = 3'b000;
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_first_lock();
        t_hold_mid();
        t_clear_relock();
        t_restart();
        t_gaps();
        t_mux();
      end
      begin
        repeat (20000) @(posedge clk);
        check(1'b0, "watchdog expired", 0, 1);
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule